// File: doc/BRIEF.md
# Byte-Wide One-Time-Programmable Memory Emulator

This block stands in for a byte-wide one-time-programmable memory inside a larger design or an emulation platform. It takes the part's control pins as plain logic levels: an active-low chip select, an active-low output gate, a flag saying the programming supply is present, and a flag saying address line 9 carries the high identification voltage. From these it works out the operating mode and serves array reads, identifier reads or program writes. Analog levels and access delays are not modelled; the output is a byte plus a separate drive-enable that stands for the tri-state condition.

The storage is a small array of `2**IDX_W` bytes, addressed by the low address bits. It comes out of reset as all ones. A program write can only clear bits: the stored word becomes the old word ANDed with the input byte. Writes are taken once per falling edge of chip select, seen through the system clock, so a long or slow pulse still writes only once. A 3-bit mode output reports the decoded mode.

Top module: `otp_emu`

## Requirements
- R1: While reset is held, every array word is set to 0xFF; after reset, reading any word returns 0xFF until it is programmed.
- R2: With chip select low, output gate low, supply flag 0 and identification flag 0, the mode output is 1 (read), the drive-enable is 1 and the data output is the array word selected by the low `IDX_W` address bits.
- R3: With chip select low, output gate high and supply flag 0, the mode output is 2 (output off) and the drive-enable is 0.
- R4: With chip select high and supply flag 0, the mode output is 0 (standby) and the drive-enable is 0, whatever the output gate and identification flag are.
- R5: With supply flag 1, output gate high, identification flag 0 and chip select low, the mode output is 3 (program) and the drive-enable is 0; at the first clock edge that sees chip select low after seeing it high, the addressed word becomes its old value ANDed with the data input.
- R6: With supply flag 1, chip select high and output gate low, the mode output is 4 (verify), the drive-enable is 1 and the data output is the stored word at the address.
- R7: With supply flag 1 and both chip select and output gate high, the mode output is 5 (inhibit), the drive-enable is 0 and no word changes.
- R8: With supply flag 0, chip select low, output gate low, identification flag 1 and every address bit other than bits 0 and 9 at 0, the mode output is 6 (identify), the drive-enable is 1 and the data output is 0x20 when address bit 0 is 0 and 0xB4 when it is 1; the array is not changed.
- R9: The mode output is 7 (illegal), the drive-enable is 0 and no write occurs when the identification flag is 1 with chip select and output gate low but some address bit other than bits 0 and 9 set, when the supply flag is 1 with chip select and output gate both low, or when the identification flag and supply flag are both 1.
- R10: Address bits at and above `IDX_W` do not select the word: addresses that agree in the low `IDX_W` bits reach the same word.
- R11: A chip select low period writes exactly once, however many clock edges it spans; data input changes after the first edge have no effect, and a chip select falling edge outside program mode writes nothing.
- R12: A bit once cleared stays 0: programming a 1 into it leaves it 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples chip select for program pulses |
| rst_n | input | 1 | Active-low reset; fills the array with ones |
| ce_n | input | 1 | Chip select, active low; its falling edge is the program pulse |
| oe_n | input | 1 | Output gate, active low |
| vpp_on | input | 1 | Programming supply present |
| a9_hv | input | 1 | High identification voltage on address line 9 |
| addr | input | ADDR_W (19) | Byte address |
| din | input | DATA_W (8) | Byte to program |
| dout | output | DATA_W (8) | Output byte, 0 when not driven |
| dout_en | output | 1 | Output is driven (0 stands for high impedance) |
| mode | output | 3 | Decoded mode code, as listed in R2 to R9 |

## Verification
On every cycle the assertions check that bits never go from 0 back to 1, that a write only happens in program mode with the supply flag set, that a write is never followed by another on the next edge, that the quiet modes never drive the output, and that identify mode presents the right code for address bit 0. That stored data matches the bytes programmed, that reads and verifies return the right word, that high address bits alias, and that inhibit and illegal combinations leave the array untouched can only be shown by the bench's scenarios, which compare every read against a model array updated by AND on each program pulse.

// File: rtl/otpe_pkg.sv
package otpe_pkg;

   typedef enum logic [2:0] {
      OM_STANDBY = 3'd0,
      OM_READ    = 3'd1,
      OM_OUTOFF  = 3'd2,
      OM_PROG    = 3'd3,
      OM_VERIFY  = 3'd4,
      OM_INHIBIT = 3'd5,
      OM_IDENT   = 3'd6,
      OM_ILLEGAL = 3'd7
   } otp_mode_e;

   localparam int unsigned HV_BIT = 9;

endpackage

// File: rtl/otpe_mode_dec.sv
module otpe_mode_dec
   import otpe_pkg::*;
#(
   parameter int unsigned ADDR_W = 19
) (
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              vpp_on,
   input  logic              a9_hv,
   input  logic [ADDR_W-1:0] addr,
   output otp_mode_e         mode
);

   localparam logic [ADDR_W-1:0] KEEP_MASK = ~((ADDR_W'(1) << HV_BIT) | ADDR_W'(1));

   logic others_zero;
   assign others_zero = ((addr & KEEP_MASK) == '0);

   always_comb begin
      mode = OM_ILLEGAL;
      if (!vpp_on) begin
         if (ce_n)
            mode = OM_STANDBY;
         else if (oe_n)
            mode = OM_OUTOFF;
         else if (!a9_hv)
            mode = OM_READ;
         else if (others_zero)
            mode = OM_IDENT;
         else
            mode = OM_ILLEGAL;
      end else if (!a9_hv) begin
         unique case ({ce_n, oe_n})
            2'b01:   mode = OM_PROG;
            2'b10:   mode = OM_VERIFY;
            2'b11:   mode = OM_INHIBIT;
            default: mode = OM_ILLEGAL;
         endcase
      end
   end

endmodule

// File: rtl/otpe_pulse.sv
module otpe_pulse (
   input  logic clk,
   input  logic rst_n,
   input  logic ce_n,
   input  logic in_prog,
   output logic wr_en
);

   logic ce_n_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ce_n_q <= 1'b1;
      else
         ce_n_q <= ce_n;
   end

   assign wr_en = ce_n_q && !ce_n && in_prog;

   // R11: a write cannot be repeated on the next edge of the same pulse
   a_r11_single_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);

endmodule

// File: rtl/otpe_array.sv
module otpe_array #(
   parameter int unsigned IDX_W  = 6,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data
);

   localparam int unsigned WORDS = 1 << IDX_W;

   logic [DATA_W-1:0] cells [WORDS];

   for (genvar gi = 0; gi < WORDS; gi++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cells[gi] <= '1;
         else if (wr_en && (wr_idx == IDX_W'(gi)))
            cells[gi] <= cells[gi] & wr_data;
      end

      // R12: no bit of a word rises after reset
      a_r12_no_set: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> ((cells[gi] & ~$past(cells[gi])) == '0));
   end

   assign rd_data = cells[rd_idx];

endmodule

// File: rtl/otp_emu.sv
module otp_emu
   import otpe_pkg::*;
#(
   parameter int unsigned     ADDR_W   = 19,
   parameter int unsigned     DATA_W   = 8,
   parameter int unsigned     IDX_W    = 6,
   parameter logic [DATA_W-1:0] MFR_CODE = 8'h20,
   parameter logic [DATA_W-1:0] DEV_CODE = 8'hB4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              vpp_on,
   input  logic              a9_hv,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en,
   output logic [2:0]        mode
);

   if (ADDR_W <= HV_BIT) begin : g_bad_addr
      $error("otp_emu: ADDR_W must exceed the identification bit index");
   end
   if (IDX_W < 1 || IDX_W > 12 || IDX_W > ADDR_W) begin : g_bad_idx
      $error("otp_emu: IDX_W out of range");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("otp_emu: DATA_W must be positive");
   end

   otp_mode_e         mode_e;
   logic              wr_en;
   logic [DATA_W-1:0] rd_data;
   logic [IDX_W-1:0]  idx;

   assign idx  = addr[IDX_W-1:0];
   assign mode = mode_e;

   otpe_mode_dec #(.ADDR_W(ADDR_W)) u_dec (
      .ce_n   (ce_n),
      .oe_n   (oe_n),
      .vpp_on (vpp_on),
      .a9_hv  (a9_hv),
      .addr   (addr),
      .mode   (mode_e)
   );

   otpe_pulse u_pulse (
      .clk     (clk),
      .rst_n   (rst_n),
      .ce_n    (ce_n),
      .in_prog (mode_e == OM_PROG),
      .wr_en   (wr_en)
   );

   otpe_array #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (idx),
      .wr_data (din),
      .rd_idx  (idx),
      .rd_data (rd_data)
   );

   always_comb begin
      dout    = '0;
      dout_en = 1'b0;
      unique case (mode_e)
         OM_READ, OM_VERIFY: begin
            dout    = rd_data;
            dout_en = 1'b1;
         end
         OM_IDENT: begin
            dout    = addr[0] ? DEV_CODE : MFR_CODE;
            dout_en = 1'b1;
         end
         default: ;
      endcase
   end

   // R4: quiet modes never drive the output
   a_r4_quiet_modes: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_e inside {OM_STANDBY, OM_OUTOFF, OM_PROG, OM_INHIBIT, OM_ILLEGAL}) |-> !dout_en);

   // R5: a write needs program mode with the supply present
   a_r5_write_in_prog: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (vpp_on && oe_n && !ce_n && mode == 3'd3));

   // R8: identify mode presents the code chosen by address bit 0
   a_r8_ident_code: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_e == OM_IDENT) |-> (dout_en && dout == (addr[0] ? DEV_CODE : MFR_CODE)));

endmodule

// File: tb/otp_emu_tb.sv
module otp_emu_tb;

   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 19;
   localparam int DATA_W = 8;
   localparam int IDX_W  = 6;
   localparam int WORDS  = 1 << IDX_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ce_n = 1'b1;
   logic              oe_n = 1'b1;
   logic              vpp_on = 1'b0;
   logic              a9_hv = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic [DATA_W-1:0] din = '0;
   logic [DATA_W-1:0] dout;
   logic              dout_en;
   logic [2:0]        mode;

   int checks = 0;
   int errors = 0;
   logic [DATA_W-1:0] model [WORDS];

   always #(CLK_PERIOD/2) clk = ~clk;

   otp_emu #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .vpp_on(vpp_on),
      .a9_hv(a9_hv), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
      .mode(mode)
   );

   function automatic logic [2:0] exp_mode(input logic c, input logic o, input logic v,
                                           input logic h, input logic [ADDR_W-1:0] a);
      logic [ADDR_W-1:0] rest;
      rest = a & ~((ADDR_W'(1) << 9) | ADDR_W'(1));
      if (!v) begin
         if (c) return 3'd0;
         if (o) return 3'd2;
         if (!h) return 3'd1;
         return (rest == '0) ? 3'd6 : 3'd7;
      end
      if (h) return 3'd7;
      case ({c, o})
         2'b01:   return 3'd3;
         2'b10:   return 3'd4;
         2'b11:   return 3'd5;
         default: return 3'd7;
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   // check mode, drive-enable and data against the model for current inputs
   task automatic check_outputs(input string req);
      logic [2:0] em;
      logic       een;
      logic [7:0] ed;
      em  = exp_mode(ce_n, oe_n, vpp_on, a9_hv, addr);
      een = (em == 3'd1) || (em == 3'd4) || (em == 3'd6);
      ed  = (em == 3'd6) ? (addr[0] ? 8'hB4 : 8'h20) : model[addr[IDX_W-1:0]];
      check(mode == em, {req, " mode"}, 32'(mode), 32'(em));
      check(dout_en == een, {req, " dout_en"}, 32'(dout_en), 32'(een));
      if (een) check(dout == ed, {req, " dout"}, 32'(dout), 32'(ed));
   endtask

   task automatic do_read(input logic [ADDR_W-1:0] a, input string req);
      @(negedge clk);
      vpp_on = 1'b0; a9_hv = 1'b0; ce_n = 1'b0; oe_n = 1'b0; addr = a;
      #1 check_outputs(req);
   endtask

   task automatic do_verify(input logic [ADDR_W-1:0] a, input string req);
      @(negedge clk);
      vpp_on = 1'b1; a9_hv = 1'b0; ce_n = 1'b1; oe_n = 1'b0; addr = a;
      #1 check_outputs(req);
   endtask

   // program pulse with chip select held low for hold cycles
   task automatic do_prog(input logic [ADDR_W-1:0] a, input logic [7:0] d, input int hold);
      @(negedge clk);
      vpp_on = 1'b1; a9_hv = 1'b0; oe_n = 1'b1; ce_n = 1'b1; addr = a; din = d;
      @(negedge clk);
      ce_n = 1'b0;
      #1 check_outputs("R5 program");
      for (int k = 1; k < hold; k++) begin
         @(negedge clk);
         din = ~d;                       // R11: late data must not be written
      end
      @(negedge clk);
      ce_n = 1'b1;
      model[a[IDX_W-1:0]] = model[a[IDX_W-1:0]] & d;
   endtask

   // arbitrary control combination held across one clock edge
   task automatic do_combo(input logic c, input logic o, input logic v, input logic h,
                           input logic [ADDR_W-1:0] a, input logic [7:0] d, input string req);
      logic [2:0] em;
      @(negedge clk);
      ce_n = 1'b1;
      @(negedge clk);
      ce_n = c; oe_n = o; vpp_on = v; a9_hv = h; addr = a; din = d;
      em = exp_mode(c, o, v, h, a);
      #1 check_outputs(req);
      @(negedge clk);
      if (em == 3'd3) model[a[IDX_W-1:0]] = model[a[IDX_W-1:0]] & d;
      ce_n = 1'b1;
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      void'($urandom(32'h0C0FFEE5));
      for (int i = 0; i < WORDS; i++) model[i] = 8'hFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1 check(mode == 3'd0 && dout_en == 1'b0, "R1 reset standby", 32'(mode), 32'd0);

      // R1: whole array reads ones
      for (int i = 0; i < WORDS; i++) do_read(ADDR_W'(i), "R1 erased");

      // R3, R4
      do_combo(1'b0, 1'b1, 1'b0, 1'b0, 19'h00011, 8'h00, "R3 output off");
      do_combo(1'b1, 1'b0, 1'b0, 1'b1, 19'h00200, 8'h00, "R4 standby gate low");
      do_combo(1'b1, 1'b1, 1'b0, 1'b0, 19'h7FFFF, 8'h00, "R4 standby gate high");

      // R5, R2, R6: program and read back
      do_prog(19'h00005, 8'hA5, 1);
      do_read(19'h00005, "R2 read programmed");
      do_verify(19'h00005, "R6 verify programmed");
      // R12: ones cannot come back
      do_prog(19'h00005, 8'hFF, 1);
      do_prog(19'h00005, 8'h0F, 1);
      do_verify(19'h00005, "R12 bits stay cleared");
      check(dout == 8'h05, "R12 value", 32'(dout), 32'h05);

      // R11: long pulse writes once, late data ignored
      do_prog(19'h00010, 8'hF0, 5);
      do_verify(19'h00010, "R11 long pulse");
      check(dout == 8'hF0, "R11 value", 32'(dout), 32'hF0);

      // R11: falling select in read mode writes nothing
      @(negedge clk);
      vpp_on = 1'b0; oe_n = 1'b0; ce_n = 1'b1; addr = 19'h00020; din = 8'h00;
      @(negedge clk); ce_n = 1'b0;
      @(negedge clk); ce_n = 1'b1;
      do_read(19'h00020, "R11 no write in read");

      // R10: aliasing of high address bits
      do_prog(19'h4C003, 8'h3C, 1);
      do_read(19'h00003, "R10 alias low");
      check(dout == 8'h3C, "R10 value", 32'(dout), 32'h3C);
      do_verify(19'h7FFC3, "R10 alias high");

      // R7: inhibit held over a select edge of no effect
      do_combo(1'b1, 1'b1, 1'b1, 1'b0, 19'h00021, 8'h00, "R7 inhibit");
      do_read(19'h00021, "R7 no write");

      // R8: identify codes; array left alone
      do_combo(1'b0, 1'b0, 1'b0, 1'b1, 19'h00000, 8'h00, "R8 maker code");
      check(dout == 8'h20, "R8 maker", 32'(dout), 32'h20);
      do_combo(1'b0, 1'b0, 1'b0, 1'b1, 19'h00201, 8'h00, "R8 device code");
      check(dout == 8'hB4, "R8 device", 32'(dout), 32'hB4);
      do_read(19'h00000, "R8 array untouched");

      // R9: illegal combinations, no drive, no write
      do_combo(1'b0, 1'b0, 1'b0, 1'b1, 19'h00004, 8'h00, "R9 ident bad addr");
      do_combo(1'b0, 1'b0, 1'b1, 1'b0, 19'h00022, 8'h00, "R9 supply both low");
      do_combo(1'b0, 1'b1, 1'b1, 1'b1, 19'h00023, 8'h00, "R9 hv with supply");
      do_read(19'h00022, "R9 no write a");
      do_read(19'h00023, "R9 no write b");

      // random mix
      for (int n = 0; n < 400; n++) begin
         logic [ADDR_W-1:0] ra;
         logic [7:0] rd;
         int sel;
         ra  = ADDR_W'($urandom);
         rd  = 8'($urandom);
         sel = $urandom_range(0, 3);
         if ($urandom_range(0, 3) == 0) ra = ra & ((ADDR_W'(1) << 9) | ADDR_W'(1));
         case (sel)
            0: do_prog(ra, rd, $urandom_range(1, 3));
            1: do_read(ra, "R2 random read");
            2: do_verify(ra, "R6 random verify");
            default: do_combo(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                              ra, rd, "R9 random combo");
         endcase
      end

      // final sweep of the array
      for (int i = 0; i < WORDS; i++) do_verify(ADDR_W'(i), "R12 final sweep");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule